// File: doc/BRIEF.md
# Differential GMSK Symbol Detector with Frequency Correction

This block recovers data bits from a baseband GMSK burst that has already been sampled once per symbol. Each sample is an I/Q pair in sign-magnitude form. The block turns every pair into an 8-bit phase angle and takes the change in angle from the previous symbol. It removes a constant per-symbol rotation caused by carrier frequency offset. It then sorts the corrected change into one of three transition codes, and a small state machine turns the codes into a bit stream.

A burst begins with a one-cycle start pulse. The first sample after the pulse only sets the phase reference. The next sixteen phase changes are summed to learn the frequency offset, and no correction is applied to them. From then on the rounded average is frozen and subtracted from every later phase change until the next start pulse. The decision threshold is a static input, so the detector can trade noise immunity against sensitivity to small phase steps.

Top module: `gmsk_diff_detector`

## Requirements
- R1: After reset, bitValid is 0, bitOut is 0 and transCode is 00.
- R2: Until the first startDet pulse after reset, valid samples are ignored and bitValid stays 0.
- R3: Each 6-bit input uses bit 5 as the sign (1 = negative) and bits 4:0 as the magnitude. The phase angle uses 256 counts per turn, rising anticlockwise from the +I axis: +Q gives 64, −I gives 128, −Q gives 192 and each diagonal gives an odd multiple of 32. Inside an octant the angle comes from a 17-step table indexed by floor(16·min/max) of the magnitudes.
- R4: The sample taken with startDet, or the first valid sample after it, only sets the reference and produces no bit. Every later valid sample produces exactly one bitValid pulse, two clock edges after the edge that takes the sample.
- R5: The corrected difference is a signed 8-bit value in −128..127, wrapping modulo 256. It gives transCode 01 when it is greater than threshold, 10 when it is less than −threshold, and 00 otherwise.
- R6: On code 01 bitOut becomes 1, on code 10 it becomes 0, and on code 00 it keeps its previous value.
- R7: The first 16 differences after a start are decoded with zero correction. When the 16th is decoded, the estimate becomes floor((sum + 8) / 16) of those 16 signed differences.
- R8: After training, every difference has the frozen estimate subtracted from it, and the estimate does not change until the next startDet.
- R9: startDet clears bitOut to 0, the estimate and the training count. A sample valid in the same cycle becomes the new reference, and a difference still in flight from before the pulse is dropped without a bitValid pulse.
- R10: A corrected difference exactly equal to +threshold or −threshold gives code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startDet | input | 1 | One-cycle pulse that starts a new burst |
| sampleValid | input | 1 | sampleI and sampleQ hold a symbol-rate sample |
| sampleI | input | 6 | In-phase sample, sign-magnitude |
| sampleQ | input | 6 | Quadrature sample, sign-magnitude |
| threshold | input | 7 | Decision threshold in angle counts |
| bitValid | output | 1 | One-cycle pulse: bitOut and transCode are new |
| bitOut | output | 1 | Recovered data bit |
| transCode | output | 2 | Transition code of the latest symbol (01 up, 10 down, 00 hold) |

## Verification
The bench walks the phase through all four quadrants and across the 255-to-0 seam. A wrong wrap would turn a +96 step into −160 and flip the decision, and a mishandled negative zero would put the −I axis in the wrong half. It sets the threshold exactly on ±32 and one count below, so a comparison that includes the boundary shows up as a wrong code. Frequency training is checked with a uniform +32 drift and with a sum of 10, where the correct estimate is 1 and truncation would give 0. A restart during tracking is also tested: a design that keeps its old estimate or forwards the stale in-flight difference produces a wrong code or an extra bit pulse.

// File: rtl/gmsk_det_pkg.sv
package gmsk_det_pkg;

  // Angle resolution: 256 counts per full turn.
  localparam int ANGLE_W = 8;
  // Ratio resolution inside one octant: 2**RATIO_W steps.
  localparam int RATIO_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_TRACK = 2'd2
  } detStateT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;     // restart of a burst
    logic capture;   // load the phase reference
    logic diffLoad;  // register a new phase difference
    logic emit;      // decode the registered difference
    logic accum;     // add the difference into the training sum
    logic lock;      // freeze the frequency estimate
    logic useEst;    // subtract the frozen estimate
  } detStrobeT;

  localparam logic [1:0] CODE_HOLD = 2'b00;
  localparam logic [1:0] CODE_UP   = 2'b01;
  localparam logic [1:0] CODE_DOWN = 2'b10;

  // Angle in counts of atan(k/16), k = 0..16, for 256 counts per turn.
  function automatic logic [ANGLE_W-3:0] octantAngle(input logic [RATIO_W:0] k);
    logic [ANGLE_W-3:0] a;
    case (k)
      5'd0:  a = 6'd0;
      5'd1:  a = 6'd3;
      5'd2:  a = 6'd5;
      5'd3:  a = 6'd8;
      5'd4:  a = 6'd10;
      5'd5:  a = 6'd12;
      5'd6:  a = 6'd15;
      5'd7:  a = 6'd17;
      5'd8:  a = 6'd19;
      5'd9:  a = 6'd21;
      5'd10: a = 6'd23;
      5'd11: a = 6'd25;
      5'd12: a = 6'd26;
      5'd13: a = 6'd28;
      5'd14: a = 6'd29;
      5'd15: a = 6'd31;
      default: a = 6'd32;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/gmsk_phase_angle.sv
module gmsk_phase_angle
  import gmsk_det_pkg::*;
#(
  parameter int MAG_W = 5
) (
  input  logic [MAG_W:0]       inI,
  input  logic [MAG_W:0]       inQ,
  output logic [ANGLE_W-1:0]   angle
);

  localparam int NUM_W = MAG_W + RATIO_W;
  localparam logic [ANGLE_W-1:0] QUARTER = ANGLE_W'(1 << (ANGLE_W - 2));
  localparam logic [ANGLE_W-1:0] HALF    = ANGLE_W'(1 << (ANGLE_W - 1));

  logic [MAG_W-1:0]   magI, magQ, bigMag, smallMag;
  logic               negI, negQ, steep;
  logic [NUM_W-1:0]   numer, denom;
  logic [RATIO_W:0]   ratioIdx;
  logic [ANGLE_W-3:0] octA;
  logic [ANGLE_W-1:0] quadA;

  always_comb begin
    magI     = inI[MAG_W-1:0];
    magQ     = inQ[MAG_W-1:0];
    negI     = inI[MAG_W];
    negQ     = inQ[MAG_W];
    steep    = magQ > magI;
    bigMag   = steep ? magQ : magI;
    smallMag = steep ? magI : magQ;
    numer    = {smallMag, {RATIO_W{1'b0}}};
    denom    = {{RATIO_W{1'b0}}, bigMag};
    if (bigMag == '0) ratioIdx = '0;
    else              ratioIdx = (RATIO_W+1)'(numer / denom);
    octA  = octantAngle(ratioIdx);
    quadA = steep ? (QUARTER - ANGLE_W'(octA)) : ANGLE_W'(octA);
    case ({negI, negQ})
      2'b00:   angle = quadA;
      2'b10:   angle = HALF - quadA;
      2'b11:   angle = HALF + quadA;
      default: angle = ANGLE_W'(0) - quadA;
    endcase
  end

endmodule

// File: rtl/gmsk_det_ctrl.sv
module gmsk_det_ctrl
  import gmsk_det_pkg::*;
#(
  parameter int TRAIN_LEN = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startDet,
  input  logic      sampleValid,
  output detStrobeT strb
);

  localparam int CNT_W = $clog2(TRAIN_LEN) + 1;

  detStateT         state;
  logic             havePrev;
  logic             diffPending;
  logic [CNT_W-1:0] trainCnt;
  logic             active;

  always_comb begin
    active        = (state != ST_IDLE);
    strb.clear    = startDet;
    strb.capture  = sampleValid && (startDet || active);
    strb.diffLoad = sampleValid && active && havePrev && !startDet;
    strb.emit     = diffPending && !startDet;
    strb.accum    = strb.emit && (state == ST_TRAIN);
    strb.lock     = strb.accum && (trainCnt == CNT_W'(TRAIN_LEN - 1));
    strb.useEst   = (state == ST_TRACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      havePrev    <= 1'b0;
      diffPending <= 1'b0;
      trainCnt    <= '0;
    end else begin
      diffPending <= strb.diffLoad;
      if (startDet) begin
        state    <= ST_TRAIN;
        havePrev <= sampleValid;
        trainCnt <= '0;
      end else begin
        if (strb.capture) havePrev <= 1'b1;
        if (strb.accum)   trainCnt <= trainCnt + 1'b1;
        if (strb.lock)    state    <= ST_TRACK;
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !diffPending);

  // R7
  train_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRAIN) |-> (trainCnt < CNT_W'(TRAIN_LEN)));

  // R7
  lock_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lock |=> (state == ST_TRACK));

endmodule

// File: rtl/gmsk_det_datapath.sv
module gmsk_det_datapath
  import gmsk_det_pkg::*;
#(
  parameter int MAG_W     = 5,
  parameter int TRAIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  detStrobeT          strb,
  input  logic [MAG_W:0]     sampleI,
  input  logic [MAG_W:0]     sampleQ,
  input  logic [ANGLE_W-2:0] threshold,
  output logic               bitValid,
  output logic               bitOut,
  output logic [1:0]         transCode
);

  localparam int TRAIN_LOG = $clog2(TRAIN_LEN);
  localparam int SUM_W     = ANGLE_W + TRAIN_LOG;
  localparam logic signed [SUM_W-1:0] ROUND_ADD = SUM_W'(TRAIN_LEN / 2);

  logic [ANGLE_W-1:0]        phaseNow, prevPhase, diffReg, estSel;
  logic signed [ANGLE_W-1:0] estReg, corrNow, thrPos, thrNeg;
  logic signed [SUM_W-1:0]   accSum, sumNext, sumRound;
  logic [1:0]                codeNow;
  logic                      nextBit;

  gmsk_phase_angle #(.MAG_W(MAG_W)) phaseCalc (
    .inI   (sampleI),
    .inQ   (sampleQ),
    .angle (phaseNow)
  );

  always_comb begin
    sumNext  = accSum + {{(SUM_W-ANGLE_W){diffReg[ANGLE_W-1]}}, diffReg};
    sumRound = sumNext + ROUND_ADD;
    estSel   = strb.useEst ? estReg : '0;
    corrNow  = diffReg - estSel;
    thrPos   = {1'b0, threshold};
    thrNeg   = -thrPos;
    if (corrNow > thrPos)      codeNow = CODE_UP;
    else if (corrNow < thrNeg) codeNow = CODE_DOWN;
    else                       codeNow = CODE_HOLD;
    case (codeNow)
      CODE_UP:   nextBit = 1'b1;
      CODE_DOWN: nextBit = 1'b0;
      default:   nextBit = bitOut;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= '0;
      diffReg   <= '0;
      accSum    <= '0;
      estReg    <= '0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
      transCode <= CODE_HOLD;
    end else begin
      if (strb.capture)  prevPhase <= phaseNow;
      if (strb.diffLoad) diffReg   <= phaseNow - prevPhase;
      bitValid <= strb.emit;
      if (strb.clear) begin
        accSum    <= '0;
        estReg    <= '0;
        bitOut    <= 1'b0;
        transCode <= CODE_HOLD;
      end else if (strb.emit) begin
        bitOut    <= nextBit;
        transCode <= codeNow;
        if (strb.accum) accSum <= sumNext;
        if (strb.lock)  estReg <= ANGLE_W'(sumRound >>> TRAIN_LOG);
      end
    end
  end

  // R6
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && (codeNow == CODE_HOLD)) |=> $stable(bitOut));

  // R6
  up_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && (transCode == CODE_UP)) |-> bitOut);

  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(transCode));

  // R8
  est_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useEst && !strb.clear) |=> $stable(estReg));

endmodule

// File: rtl/gmsk_diff_detector.sv
module gmsk_diff_detector
  import gmsk_det_pkg::*;
#(
  parameter int SAMPLE_W  = 6,
  parameter int TRAIN_LEN = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startDet,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic [ANGLE_W-2:0]  threshold,
  output logic                bitValid,
  output logic                bitOut,
  output logic [1:0]          transCode
);

  localparam int MAG_W = SAMPLE_W - 1;

  detStrobeT strb;

  gmsk_det_ctrl #(.TRAIN_LEN(TRAIN_LEN)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startDet    (startDet),
    .sampleValid (sampleValid),
    .strb        (strb)
  );

  gmsk_det_datapath #(.MAG_W(MAG_W), .TRAIN_LEN(TRAIN_LEN)) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sampleI   (sampleI),
    .sampleQ   (sampleQ),
    .threshold (threshold),
    .bitValid  (bitValid),
    .bitOut    (bitOut),
    .transCode (transCode)
  );

endmodule

// File: tb/gmsk_diff_detector_test.sv
module gmsk_diff_detector_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startDet, sampleValid;
  logic [5:0] sampleI, sampleQ;
  logic [6:0] threshold;
  logic       bitValid, bitOut;
  logic [1:0] transCode;

  always #5 clk = ~clk;

  gmsk_diff_detector uut (
    .clk, .rstN, .startDet, .sampleValid, .sampleI, .sampleQ,
    .threshold, .bitValid, .bitOut, .transCode
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model state (from the requirements).
  int mPrev, mCnt, mSum, mEst, mBit, mTrack, thr;

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wrap8(int v);
    int w;
    w = v & 255;
    if (w > 127) w = w - 256;
    return w;
  endfunction

  function automatic logic [5:0] sm(int v);
    if (v < 0) return {1'b1, 5'(-v)};
    return {1'b0, 5'(v)};
  endfunction

  // Eight directions at multiples of 32 counts (R3).
  function automatic int dirI(int k);
    case (k % 8)
      0: return 20;  1: return 14;  2: return 0;  3: return -14;
      4: return -20; 5: return -14; 6: return 0;  default: return 14;
    endcase
  endfunction
  function automatic int dirQ(int k);
    case (k % 8)
      0: return 0;   1: return 14;  2: return 20;  3: return 14;
      4: return 0;   5: return -14; 6: return -20; default: return -14;
    endcase
  endfunction

  task automatic setThr(int t);
    thr = t;
    threshold = 7'(t);
  endtask

  task automatic modelRestart(int ang);
    mPrev = ang; mCnt = 0; mSum = 0; mEst = 0; mBit = 0; mTrack = 0;
  endtask

  // Begins and ends at a falling edge.
  task automatic startSession(logic [5:0] i, logic [5:0] q, int ang);
    startDet = 1'b1; sampleValid = 1'b1; sampleI = i; sampleQ = q;
    @(posedge clk);
    @(negedge clk);
    startDet = 1'b0; sampleValid = 1'b0;
    modelRestart(ang);
    checkEq("R9 restart clears bitOut", int'(bitOut), 0);
    @(posedge clk);
    @(negedge clk);
    checkEq("R4 reference sample gives no bit", int'(bitValid), 0);
  endtask

  task automatic sendSym(logic [5:0] i, logic [5:0] q, int ang, string tag);
    int d, corr, code, expPack, actPack;
    sampleValid = 1'b1; sampleI = i; sampleQ = q;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    checkEq({tag, " R4 no bit after one edge"}, int'(bitValid), 0);
    @(posedge clk);
    @(negedge clk);
    d    = wrap8(ang - mPrev);
    corr = wrap8(d - (mTrack != 0 ? mEst : 0));
    if (corr > thr)       code = 1;
    else if (corr < -thr) code = 2;
    else                  code = 0;
    if (code == 1) mBit = 1;
    if (code == 2) mBit = 0;
    if (mTrack == 0) begin
      mSum += d;
      mCnt++;
      if (mCnt == 16) begin
        mEst   = (mSum + 8) >>> 4;
        mTrack = 1;
      end
    end
    mPrev   = ang;
    expPack = 8 + code * 2 + mBit;
    actPack = int'(bitValid) * 8 + int'(transCode) * 2 + int'(bitOut);
    checkEq({tag, " {valid,code,bit}"}, actPack, expPack);
  endtask

  task automatic testReset();
    rstN = 1'b0; startDet = 1'b0; sampleValid = 1'b0;
    sampleI = '0; sampleQ = '0; setThr(20);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkEq("R1 bitValid after reset", int'(bitValid), 0);
    checkEq("R1 bitOut after reset", int'(bitOut), 0);
    checkEq("R1 transCode after reset", int'(transCode), 0);
  endtask

  task automatic testIdle();
    for (int k = 0; k < 6; k++) begin
      sampleValid = 1'b1; sampleI = sm(dirI(k)); sampleQ = sm(dirQ(k));
      @(posedge clk);
      @(negedge clk);
      checkEq("R2 no bit before first start", int'(bitValid), 0);
    end
    sampleValid = 1'b0;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      checkEq("R2 no bit before first start", int'(bitValid), 0);
    end
  endtask

  task automatic testQuadrants();
    setThr(20);
    startSession(sm(20), sm(0), 0);
    sendSym(sm(0),   sm(20),  64,  "R3 +Q axis");
    sendSym(sm(-20), sm(0),   128, "R3 -I axis");
    sendSym(sm(-10), sm(-10), 160, "R3 third diagonal");
    sendSym(sm(0),   sm(-20), 192, "R3 -Q axis");
    sendSym(sm(20),  sm(-20), 224, "R3 fourth diagonal");
    sendSym(sm(20),  sm(0),   0,   "R5 wrap 224 to 0");
    sendSym(sm(5),   sm(-5),  224, "R6 down step");
    sendSym(sm(7),   sm(-7),  224, "R6 zero step holds");
    sendSym(sm(0),   sm(31),  64,  "R5 -160 wraps to +96");
    sendSym(sm(-31), 6'b100000, 128, "R3 negative zero Q");
    sendSym(sm(12),  sm(0),   0,   "R5 step of -128");
  endtask

  task automatic testThreshold();
    setThr(32);
    startSession(sm(20), sm(0), 0);
    sendSym(sm(14), sm(14), 32, "R10 diff equals +T");
    sendSym(sm(20), sm(0),  0,  "R10 diff equals -T");
    setThr(31);
    sendSym(sm(14), sm(14), 32, "R10 diff one above T");
    sendSym(sm(20), sm(0),  0,  "R10 diff one below -T");
  endtask

  task automatic testAfcLock();
    setThr(20);
    startSession(sm(dirI(0)), sm(dirQ(0)), 0);
    for (int k = 1; k <= 16; k++)
      sendSym(sm(dirI(k)), sm(dirQ(k)), (k * 32) % 256, "R7 training uncorrected");
    sendSym(sm(dirI(1)), sm(dirQ(1)), 32,  "R8 drift removed");
    sendSym(sm(dirI(1)), sm(dirQ(1)), 32,  "R8 zero step reads as down");
    sendSym(sm(dirI(4)), sm(dirQ(4)), 128, "R8 +96 step reads as up");
    sendSym(sm(dirI(5)), sm(dirQ(5)), 160, "R8 estimate held");
  endtask

  task automatic testRounding();
    setThr(0);
    startSession(sm(20), sm(0), 0);
    for (int k = 0; k < 16; k++)
      sendSym(sm(16), sm(4), 10, "R7 training with sum 10");
    sendSym(sm(16), sm(4), 10, "R7 rounded estimate of 1");
  endtask

  task automatic testRestart();
    setThr(0);
    sendSym(sm(0), sm(20), 64, "R9 bit set before restart");
    startSession(sm(16), sm(4), 10);
    sendSym(sm(16), sm(4), 10, "R9 estimate cleared");
    // Restart while a difference is in flight.
    sampleValid = 1'b1; sampleI = sm(0); sampleQ = sm(20);
    @(posedge clk);
    @(negedge clk);
    startDet = 1'b1; sampleI = sm(20); sampleQ = sm(0);
    @(posedge clk);
    @(negedge clk);
    startDet = 1'b0; sampleValid = 1'b0;
    modelRestart(0);
    checkEq("R9 in-flight difference dropped", int'(bitValid), 0);
    @(posedge clk);
    @(negedge clk);
    checkEq("R9 no late bit after restart", int'(bitValid), 0);
    sendSym(sm(0), sm(20), 64, "R9 new reference used");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testIdle();
    testQuadrants();
    testThreshold();
    testAfcLock();
    testRounding();
    testRestart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R4 watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule